// File: doc/BRIEF.md
# Centralized Pipeline Depth Switch Sequencer

This block controls a pipeline that can run either at full depth, with every stage register in use, or at reduced depth, where chosen stage registers are bypassed so that neighbouring stages merge into one. A single controller owns every stage's stall and bypass decisions. When asked to change depth, it walks through a fixed sequence of stall patterns, one pattern per clock. It then raises a one-cycle completion pulse for all stages together and records the new depth. The stages do not talk to each other. Each stage only turns the controller's outputs into a local clock enable and a bypass select.

Going to reduced depth, the stall front moves from the head toward the tail, two stages per step after the first. Going back to full depth, it moves one stage per step from the tail toward the head. Each stage has a fixed advance offset. The offset lets that stage's stall reach it earlier than its nominal step, which covers a longer wire from the controller. The stall frequency source is assumed to hold its frequency steady while a sequence runs.

Top module: `pipe_depth_sequencer`

## Requirements
- R1: After reset the block is in full-depth mode (`short_mode_o`=0). `busy_o` and `done_o` are 0, both stall vectors are all zero, every `stage_clk_en_o` bit is 1 and every `stage_bypass_o` bit is 0.
- R2: A request for reduced depth is accepted at a clock edge when the block is idle in full-depth mode, `req_short_i`=1 and `req_long_i`=0. Starting on the cycle after that edge, `l2s_stall_o` shows one pattern per cycle for steps 0 to (NUM_STAGES-1)/2. Bit i is stage i, and bit 0 is the head. Stage i is set from step (i+1)/2 onward (integer division). With 5 stages and zero offsets this gives 00001, 00111, 11111, and `s2l_stall_o` stays zero throughout.
- R3: A request for full depth is accepted when the block is idle in reduced-depth mode, `req_long_i`=1 and `req_short_i`=0. `s2l_stall_o` then runs through steps 0 to NUM_STAGES-1, and stage i is set from step NUM_STAGES-1-i onward. With 5 stages and zero offsets this gives 10000, 11000, 11100, 11110, 11111, and `l2s_stall_o` stays zero throughout.
- R4: The cycle after the last step, `done_o` is 1 for exactly one cycle and the active stall vector is all ones. In the next cycle both stall vectors are zero and `short_mode_o` holds the new mode. The mode changes at no other time.
- R5: `busy_o` is 1 from the cycle after acceptance through the `done_o` cycle, and 0 otherwise.
- R6: Requests are dropped in these cases: any request that arrives while `busy_o` is 1, a request for the mode already active, and `req_short_i` together with `req_long_i`. A dropped request leaves `busy_o` at 0 and the stall vectors at zero on the following cycle.
- R7: Stage i has an advance offset, a 4-bit field `ADV_OFFSET[4i+3:4i]`. Its stall bit is set from step max(nominal step - offset, 0) instead of its nominal step.
- R8: `stage_clk_en_o[i]` is 0 exactly when `l2s_stall_o[i]` or `s2l_stall_o[i]` is 1.
- R9: `stage_bypass_o` changes only at the edge that ends the `done_o` cycle. After a switch to reduced depth it equals `MERGE_MASK`, and after a switch to full depth it is all zeros.
- R10: `l2s_stall_o` and `s2l_stall_o` are never non-zero in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_short_i | input | 1 | Request a switch to reduced depth |
| req_long_i | input | 1 | Request a switch to full depth |
| l2s_stall_o | output | NUM_STAGES | Per-stage stall while going to reduced depth |
| s2l_stall_o | output | NUM_STAGES | Per-stage stall while going to full depth |
| done_o | output | 1 | One-cycle completion pulse to all stages |
| busy_o | output | 1 | A switch sequence is in progress |
| short_mode_o | output | 1 | 1 when the pipeline is in reduced-depth mode |
| stage_clk_en_o | output | NUM_STAGES | Local clock enable of each stage |
| stage_bypass_o | output | NUM_STAGES | Local bypass select of each stage |

## Verification
A request is sampled at a rising edge, and step 0 shows on the stall outputs in the cycle right after that edge. Step k therefore appears k+1 cycles after the accepting edge. `done_o` follows one cycle after the last step, and the new mode and bypass selects appear one cycle after that. The bench drives requests and samples every output on falling edges, so it always reads the value settled since the preceding rising edge. It compares each cycle against patterns computed from the step formulas and offsets. One cycle after every dropped request, it confirms that the block is still idle.

// File: rtl/pds_pkg.sv
package pds_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

  // Step at which a stage joins the stall front with no advance.
  function automatic int nominal_step(input int stage, input int n, input logic to_short);
    if (to_short) return (stage + 1) / 2;
    return n - 1 - stage;
  endfunction

  // Index of the final pattern step for a direction.
  function automatic int final_step(input int n, input logic to_short);
    if (to_short) return (n - 1) / 2;
    return n - 1;
  endfunction

endpackage

// File: rtl/pds_step_ctrl.sv
module pds_step_ctrl
  import pds_pkg::*;
#(
  parameter int NUM_STAGES = 5,
  parameter int STEP_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_short_i,
  input  logic              req_long_i,
  output seq_state_e        state_o,
  output logic [STEP_W-1:0] step_o,
  output logic              to_short_o,
  output logic              short_mode_o,
  output logic              done_o,
  output logic              busy_o
);

  localparam logic [STEP_W-1:0] LAST_SHORT = STEP_W'(final_step(NUM_STAGES, 1'b1));
  localparam logic [STEP_W-1:0] LAST_LONG  = STEP_W'(final_step(NUM_STAGES, 1'b0));

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              dir_q, dir_d;
  logic              mode_q, mode_d;
  logic              accept;
  logic [STEP_W-1:0] last_step;

  assign accept    = (state_q == SEQ_IDLE) && (req_short_i ^ req_long_i)
                     && (req_short_i != mode_q);
  assign last_step = dir_q ? LAST_SHORT : LAST_LONG;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    dir_d   = dir_q;
    mode_d  = mode_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (accept) begin
          state_d = SEQ_RUN;
          step_d  = '0;
          dir_d   = req_short_i;
        end
      end
      SEQ_RUN: begin
        if (step_q == last_step) state_d = SEQ_DONE;
        else                     step_d  = step_q + 1'b1;
      end
      SEQ_DONE: begin
        state_d = SEQ_IDLE;
        mode_d  = dir_q;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      step_q  <= '0;
      dir_q   <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      dir_q   <= dir_d;
      mode_q  <= mode_d;
    end
  end

  assign state_o      = state_q;
  assign step_o       = step_q;
  assign to_short_o   = dir_q;
  assign short_mode_o = mode_q;
  assign done_o       = (state_q == SEQ_DONE);
  assign busy_o       = (state_q != SEQ_IDLE);

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_mode_only_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> $stable(short_mode_o));

  assert_drop_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

endmodule

// File: rtl/pds_pattern_gen.sv
module pds_pattern_gen
  import pds_pkg::*;
#(
  parameter int                         NUM_STAGES = 5,
  parameter int                         STEP_W     = 3,
  parameter int                         OFS_W      = 4,
  parameter logic [NUM_STAGES*OFS_W-1:0] ADV_OFFSET = '0
) (
  input  seq_state_e            state_i,
  input  logic [STEP_W-1:0]     step_i,
  input  logic                  to_short_i,
  output logic [NUM_STAGES-1:0] l2s_o,
  output logic [NUM_STAGES-1:0] s2l_o
);

  logic running, finishing;
  assign running   = (state_i == SEQ_RUN);
  assign finishing = (state_i == SEQ_DONE);

  for (genvar gi = 0; gi < NUM_STAGES; gi++) begin : g_stage
    localparam int OFS   = int'(ADV_OFFSET[gi*OFS_W +: OFS_W]);
    localparam int NOM_S = nominal_step(gi, NUM_STAGES, 1'b1);
    localparam int NOM_L = nominal_step(gi, NUM_STAGES, 1'b0);
    localparam logic [STEP_W-1:0] THR_S = STEP_W'((NOM_S > OFS) ? (NOM_S - OFS) : 0);
    localparam logic [STEP_W-1:0] THR_L = STEP_W'((NOM_L > OFS) ? (NOM_L - OFS) : 0);

    logic hit_s, hit_l;
    always_comb begin
      hit_s = finishing || (running && (step_i >= THR_S));
      hit_l = finishing || (running && (step_i >= THR_L));
      l2s_o[gi] = to_short_i  && hit_s;
      s2l_o[gi] = !to_short_i && hit_l;
    end
  end

endmodule

// File: rtl/pds_stage_gate.sv
module pds_stage_gate #(
  parameter logic MERGEABLE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic l2s_i,
  input  logic s2l_i,
  input  logic done_i,
  output logic clk_en_o,
  output logic bypass_o
);

  logic bypass_q, bypass_d;

  always_comb begin
    bypass_d = bypass_q;
    if (done_i) bypass_d = MERGEABLE & l2s_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bypass_q <= 1'b0;
    else        bypass_q <= bypass_d;
  end

  assign clk_en_o = !(l2s_i || s2l_i);
  assign bypass_o = bypass_q;

  assert_bypass_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> $stable(bypass_o));

  assert_bypass_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && s2l_i) |=> !bypass_o);

endmodule

// File: rtl/pipe_depth_sequencer.sv
module pipe_depth_sequencer
  import pds_pkg::*;
#(
  parameter int                         NUM_STAGES = 5,
  parameter int                         OFS_W      = 4,
  parameter logic [NUM_STAGES-1:0]       MERGE_MASK = 5'b01010,
  parameter logic [NUM_STAGES*OFS_W-1:0] ADV_OFFSET = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_short_i,
  input  logic                  req_long_i,
  output logic [NUM_STAGES-1:0] l2s_stall_o,
  output logic [NUM_STAGES-1:0] s2l_stall_o,
  output logic                  done_o,
  output logic                  busy_o,
  output logic                  short_mode_o,
  output logic [NUM_STAGES-1:0] stage_clk_en_o,
  output logic [NUM_STAGES-1:0] stage_bypass_o
);

  localparam int STEP_W = $clog2(NUM_STAGES + 1);

  seq_state_e        state;
  logic [STEP_W-1:0] step;
  logic              to_short;

  pds_step_ctrl #(
    .NUM_STAGES (NUM_STAGES),
    .STEP_W     (STEP_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_short_i  (req_short_i),
    .req_long_i   (req_long_i),
    .state_o      (state),
    .step_o       (step),
    .to_short_o   (to_short),
    .short_mode_o (short_mode_o),
    .done_o       (done_o),
    .busy_o       (busy_o)
  );

  pds_pattern_gen #(
    .NUM_STAGES (NUM_STAGES),
    .STEP_W     (STEP_W),
    .OFS_W      (OFS_W),
    .ADV_OFFSET (ADV_OFFSET)
  ) u_pat (
    .state_i    (state),
    .step_i     (step),
    .to_short_i (to_short),
    .l2s_o      (l2s_stall_o),
    .s2l_o      (s2l_stall_o)
  );

  for (genvar gi = 0; gi < NUM_STAGES; gi++) begin : g_gate
    pds_stage_gate #(
      .MERGEABLE (MERGE_MASK[gi])
    ) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .l2s_i    (l2s_stall_o[gi]),
      .s2l_i    (s2l_stall_o[gi]),
      .done_i   (done_o),
      .clk_en_o (stage_clk_en_o[gi]),
      .bypass_o (stage_bypass_o[gi])
    );
  end

  assert_one_direction_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !((|l2s_stall_o) && (|s2l_stall_o)));

  assert_done_all_stalled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (&(l2s_stall_o | s2l_stall_o)));

  assert_release_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> ((l2s_stall_o == '0) && (s2l_stall_o == '0)));

  assert_stall_needs_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(l2s_stall_o | s2l_stall_o)) |-> busy_o);

  assert_front_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=>
      (((l2s_stall_o | s2l_stall_o) & $past(l2s_stall_o | s2l_stall_o))
        == $past(l2s_stall_o | s2l_stall_o)));

  assert_mode_stable_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(short_mode_o));

endmodule

// File: tb/pipe_depth_sequencer_tb_top.sv
module pipe_depth_sequencer_tb_top;

  localparam int N        = 5;
  localparam int CLK_PER  = 10;
  localparam logic [N-1:0]   MASK  = 5'b01010;
  localparam logic [N*4-1:0] OFS_A = '0;
  localparam logic [N*4-1:0] OFS_B = {4'd1, 4'd0, 4'd0, 4'd0, 4'd2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  logic rs_a = 1'b0, rl_a = 1'b0, rs_b = 1'b0, rl_b = 1'b0;
  logic [N-1:0] l2s_a, s2l_a, ce_a, bp_a, l2s_b, s2l_b, ce_b, bp_b;
  logic done_a, busy_a, mode_a, done_b, busy_b, mode_b;

  pipe_depth_sequencer #(.NUM_STAGES(N), .OFS_W(4), .MERGE_MASK(MASK), .ADV_OFFSET(OFS_A)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_short_i(rs_a), .req_long_i(rl_a),
    .l2s_stall_o(l2s_a), .s2l_stall_o(s2l_a), .done_o(done_a), .busy_o(busy_a),
    .short_mode_o(mode_a), .stage_clk_en_o(ce_a), .stage_bypass_o(bp_a));

  pipe_depth_sequencer #(.NUM_STAGES(N), .OFS_W(4), .MERGE_MASK(MASK), .ADV_OFFSET(OFS_B)) dut_ofs_i (
    .clk(clk), .rst_n(rst_n), .req_short_i(rs_b), .req_long_i(rl_b),
    .l2s_stall_o(l2s_b), .s2l_stall_o(s2l_b), .done_o(done_b), .busy_o(busy_b),
    .short_mode_o(mode_b), .stage_clk_en_o(ce_b), .stage_bypass_o(bp_b));

  logic sel = 1'b0;
  logic [N-1:0] c_l2s, c_s2l, c_ce, c_bp;
  logic c_done, c_busy, c_mode;
  always_comb begin
    c_l2s  = sel ? l2s_b  : l2s_a;
    c_s2l  = sel ? s2l_b  : s2l_a;
    c_ce   = sel ? ce_b   : ce_a;
    c_bp   = sel ? bp_b   : bp_a;
    c_done = sel ? done_b : done_a;
    c_busy = sel ? busy_b : busy_a;
    c_mode = sel ? mode_b : mode_a;
  end

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_pat(input logic to_short, input int step,
                                           input logic [N*4-1:0] ofs);
    logic [N-1:0] p = '0;
    for (int i = 0; i < N; i++) begin
      int nom = to_short ? (i + 1) / 2 : N - 1 - i;
      int o   = int'(ofs[i*4 +: 4]);
      int thr = (nom > o) ? nom - o : 0;
      p[i] = (step >= thr);
    end
    return p;
  endfunction

  task automatic set_req(input logic s, input logic l);
    if (!sel) begin rs_a = s; rl_a = l; end
    else      begin rs_b = s; rl_b = l; end
  endtask

  task automatic check_idle(input string tag, input logic mode, input logic [N-1:0] bp);
    chk({tag, " R5 busy idle"}, {31'd0, c_busy}, 32'd0);
    chk({tag, " R4 done idle"}, {31'd0, c_done}, 32'd0);
    chk({tag, " R6 l2s zero"}, {27'd0, c_l2s}, 32'd0);
    chk({tag, " R6 s2l zero"}, {27'd0, c_s2l}, 32'd0);
    chk({tag, " R4 mode"}, {31'd0, c_mode}, {31'd0, mode});
    chk({tag, " R8 clk_en all"}, {27'd0, c_ce}, {27'd0, {N{1'b1}}});
    chk({tag, " R9 bypass"}, {27'd0, c_bp}, {27'd0, bp});
  endtask

  // One full switch; noise raises the opposite request through the busy window.
  task automatic run_switch(input string tag, input logic to_short, input logic noise,
                            input logic [N*4-1:0] ofs);
    logic [N-1:0] bp0 = c_bp;
    int last = to_short ? (N - 1) / 2 : N - 1;
    @(negedge clk); set_req(to_short, !to_short);
    @(negedge clk); set_req(noise && !to_short, noise && to_short);
    for (int s = 0; s <= last; s++) begin
      logic [N-1:0] p = exp_pat(to_short, s, ofs);
      if (s != 0) @(negedge clk);
      if (to_short) begin
        chk({tag, " R2 l2s step"}, {27'd0, c_l2s}, {27'd0, p});
        chk({tag, " R10 s2l quiet"}, {27'd0, c_s2l}, 32'd0);
      end else begin
        chk({tag, " R3 s2l step"}, {27'd0, c_s2l}, {27'd0, p});
        chk({tag, " R10 l2s quiet"}, {27'd0, c_l2s}, 32'd0);
      end
      chk({tag, " R5 busy run"}, {31'd0, c_busy}, 32'd1);
      chk({tag, " R4 no done yet"}, {31'd0, c_done}, 32'd0);
      chk({tag, " R8 clk_en run"}, {27'd0, c_ce}, {27'd0, ~p});
      chk({tag, " R9 bypass held"}, {27'd0, c_bp}, {27'd0, bp0});
      chk({tag, " R6 mode held"}, {31'd0, c_mode}, {31'd0, !to_short});
    end
    @(negedge clk);
    chk({tag, " R4 done pulse"}, {31'd0, c_done}, 32'd1);
    chk({tag, " R4 all stalled"}, {27'd0, c_l2s | c_s2l}, {27'd0, {N{1'b1}}});
    chk({tag, " R5 busy at done"}, {31'd0, c_busy}, 32'd1);
    chk({tag, " R9 bypass pre"}, {27'd0, c_bp}, {27'd0, bp0});
    @(negedge clk); set_req(1'b0, 1'b0);
    check_idle({tag, " after"}, to_short, to_short ? MASK : '0);
    @(negedge clk);
    check_idle({tag, " settled"}, to_short, to_short ? MASK : '0);
  endtask

  task automatic t_reset();
    sel = 1'b0;
    check_idle("reset R1 a", 1'b0, '0);
    sel = 1'b1;
    check_idle("reset R1 b", 1'b0, '0);
    sel = 1'b0;
  endtask

  task automatic t_drop(input string tag, input logic s, input logic l, input logic mode,
                        input logic [N-1:0] bp);
    @(negedge clk); set_req(s, l);
    @(negedge clk); set_req(1'b0, 1'b0);
    check_idle({tag, " R6 dropped"}, mode, bp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_drop("same mode long", 1'b0, 1'b1, 1'b0, '0);
    t_drop("both req", 1'b1, 1'b1, 1'b0, '0);
    run_switch("to short noisy", 1'b1, 1'b1, OFS_A);
    t_drop("same mode short", 1'b1, 1'b0, 1'b1, MASK);
    t_drop("both req short", 1'b1, 1'b1, 1'b1, MASK);
    run_switch("to long noisy", 1'b0, 1'b1, OFS_A);
    run_switch("to short", 1'b1, 1'b0, OFS_A);
    run_switch("to long", 1'b0, 1'b0, OFS_A);
    sel = 1'b1;
    run_switch("R7 ofs to short", 1'b1, 1'b0, OFS_B);
    run_switch("R7 ofs to long", 1'b0, 1'b0, OFS_B);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R5 actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule